// File: doc/BRIEF.md
# Parallel Multi-Pattern Payload Scanner

This block looks for a fixed set of phrases in packet payloads. Payload bytes arrive one per clock with markers for the first and last byte of each packet. For every packet it produces one content vector. Each bit of the vector reports whether one phrase occurred anywhere in that packet.

Each phrase has its own matching engine. An engine keeps a bit-vector automaton, so it follows every partial match at once and never backtracks. Phrases can use a wildcard for exactly one byte, a wildcard for any run of bytes (including an empty run), and a set of two accepted characters at one position. Letters match without regard to case.

A lane is a pipeline of these engines, one stage per phrase. A dispatcher sends each whole packet to the next lane in round-robin order. A collector takes the finished vectors from the lanes in the order the packets arrived.

Top module: `payload_scanner`

## Requirements
- R1: While reset is asserted and until the first packet completes, `out_valid` is low and `out_vec` is zero.
- R2: Each packet produces exactly one `out_valid` pulse of one cycle. With NPAT phrases it is asserted NPAT+1 rising edges after the edge that accepts the packet's last byte, counting that edge as the first.
- R3: The default phrase set and its vector bits are as follows. Bit 0 is `CALL NOW`. Bit 1 is `{O|0}FFER`, where the first byte is letter O or digit zero. Bit 2 is `WIN?ER`, where `?` is any one byte. Bit 3 is `MONEY*FAST`, where `*` is any run of bytes.
- R4: Letters a to z are folded to upper case before comparison, so any mix of cases matches.
- R5: The single-byte wildcard consumes exactly one byte: `winter` sets bit 2 and `winer` does not.
- R6: The run wildcard accepts zero or more bytes: both `moneyfast` and `money is fast` set bit 3, and `money fas` does not.
- R7: A two-choice position accepts either character: `0ffer` and `an offer` set bit 1, and `qffer` does not.
- R8: A phrase is found at any offset, including after a failed partial attempt that overlaps it. `calcall now` sets bit 0 and `wiwinner` sets bit 2.
- R9: A found bit stays set until the packet's last byte and is cleared at the next packet start. A phrase split across two packets is not reported.
- R10: Packets may follow each other with no idle cycle, including one-byte packets. Vectors come out in packet arrival order.
- R11: Cycles with `in_valid` low inside a packet neither advance nor reset any engine.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| in_valid | input | 1 | `in_byte` carries a payload byte this cycle |
| in_byte | input | 8 | Payload byte |
| in_sop | input | 1 | Marks the first byte of a packet |
| in_eop | input | 1 | Marks the last byte of a packet |
| out_valid | output | 1 | One-cycle strobe: `out_vec` holds a packet's result |
| out_vec | output | NPAT | Content vector, one bit per phrase as listed in R3 |

## Verification
Assertions check three things on every cycle. A found bit never drops in the middle of a packet. The dispatcher changes lane only at a packet end. The lanes finish packets one at a time and in the order the collector expects. The automaton semantics can only be shown by the bench's directed packets: case folding, the exact width of the single-byte wildcard, the empty and non-empty runs of the run wildcard, overlapping restarts and clearing at packet boundaries. The same holds for the exact latency and arrival order of back-to-back vectors.

// File: rtl/scan_pkg.sv
package scan_pkg;

  localparam int NPAT   = 4;
  localparam int MAXTOK = 10;

  typedef enum logic [1:0] {TK_LIT, TK_ANY, TK_STAR} tok_kind_e;

  typedef struct packed {
    tok_kind_e   kind;
    logic [7:0]  c0;
    logic [7:0]  c1;
  } tok_t;

  localparam logic [63:0] PH0 = "CALL NOW";
  localparam logic [31:0] PH1 = "FFER";
  localparam logic [47:0] PH2 = "WIN?ER";
  localparam logic [79:0] PH3 = "MONEY*FAST";

  function automatic tok_t lit(input logic [7:0] c);
    return '{kind: TK_LIT, c0: c, c1: c};
  endfunction

  function automatic tok_t alt2(input logic [7:0] a, input logic [7:0] b);
    return '{kind: TK_LIT, c0: a, c1: b};
  endfunction

  function automatic tok_t wild(input tok_kind_e k);
    return '{kind: k, c0: 8'h00, c1: 8'h00};
  endfunction

  function automatic int pat_len(input int p);
    case (p)
      0:       return 8;
      1:       return 5;
      2:       return 6;
      default: return 10;
    endcase
  endfunction

  // Token i of phrase p; literal characters are stored in upper case.
  function automatic tok_t pat_tok(input int p, input int i);
    tok_t t;
    case (p)
      0: t = lit(PH0[8*(7-i) +: 8]);
      1: if (i == 0) t = alt2("O", "0");
         else        t = lit(PH1[8*(4-i) +: 8]);
      2: if (i == 3) t = wild(TK_ANY);
         else        t = lit(PH2[8*(5-i) +: 8]);
      default:
         if (i == 5) t = wild(TK_STAR);
         else        t = lit(PH3[8*(9-i) +: 8]);
    endcase
    return t;
  endfunction

  function automatic logic [7:0] fold_case(input logic [7:0] b);
    return (b >= 8'h61 && b <= 8'h7a) ? (b - 8'h20) : b;
  endfunction

  function automatic logic tok_hit(input tok_t t, input logic [7:0] b);
    logic [7:0] f;
    f = fold_case(b);
    if (t.kind != TK_LIT) return 1'b1;
    return (f == t.c0) || (f == t.c1);
  endfunction

endpackage

// File: rtl/scan_engine.sv
module scan_engine
  import scan_pkg::*;
#(
  parameter int PIDX = 0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_v,
  input  logic [7:0] in_byte,
  input  logic       in_sop,
  output logic       hit_o
);

  localparam int L = pat_len(PIDX);

  logic [L:0] st_q, st_d, base, init, nxt;
  logic       hit_q, hit_d;
  tok_t       t;

  // Bit i of the state: the first i tokens have been consumed.
  always_comb begin
    init    = '0;
    init[0] = 1'b1;
    nxt     = '0;
    nxt[0]  = 1'b1;
    t       = '0;
    for (int i = 0; i < L; i++) begin
      t = pat_tok(PIDX, i);
      init[i+1] = (t.kind == TK_STAR) ? init[i] : 1'b0;
    end
    base = in_sop ? init : st_q;
    for (int i = 0; i < L; i++) begin
      t = pat_tok(PIDX, i);
      if (t.kind == TK_STAR) nxt[i+1] = nxt[i] | base[i+1];
      else                   nxt[i+1] = base[i] & tok_hit(t, in_byte);
    end
    st_d  = in_v ? nxt : st_q;
    hit_d = in_v ? ((in_sop ? 1'b0 : hit_q) | nxt[L]) : hit_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= '0;
      hit_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      hit_q <= hit_d;
    end
  end

  assign hit_o = hit_d;

  // R9: once found inside a packet, the bit stays set for later bytes
  p_hit_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_v && !in_sop && hit_q) |=> hit_q);

endmodule

// File: rtl/scan_lane.sv
module scan_lane
  import scan_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_v,
  input  logic [7:0]      in_byte,
  input  logic            in_sop,
  input  logic            in_eop,
  output logic            done_o,
  output logic [NPAT-1:0] vec_o
);

  logic            s_v   [NPAT+1];
  logic            s_eop [NPAT+1];
  logic [NPAT-1:0] s_vec [NPAT+1];
  logic            s_sop [NPAT];
  logic [7:0]      s_b   [NPAT];
  logic [NPAT-1:0] hit;

  assign s_v[0]   = in_v;
  assign s_eop[0] = in_eop;
  assign s_vec[0] = '0;
  assign s_sop[0] = in_sop;
  assign s_b[0]   = in_byte;

  for (genvar k = 0; k < NPAT; k++) begin : g_stage
    scan_engine #(.PIDX(k)) u_eng (
      .clk     (clk),
      .rst_n   (rst_n),
      .in_v    (s_v[k]),
      .in_byte (s_b[k]),
      .in_sop  (s_sop[k]),
      .hit_o   (hit[k])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s_v[k+1]   <= 1'b0;
        s_eop[k+1] <= 1'b0;
        s_vec[k+1] <= '0;
      end else begin
        s_v[k+1]   <= s_v[k];
        s_eop[k+1] <= s_v[k] & s_eop[k];
        if (s_v[k]) s_vec[k+1] <= s_vec[k] | (NPAT'(hit[k]) << k);
      end
    end

    if (k < NPAT - 1) begin : g_fwd
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          s_b[k+1]   <= '0;
          s_sop[k+1] <= 1'b0;
        end else begin
          s_b[k+1]   <= s_b[k];
          s_sop[k+1] <= s_v[k] & s_sop[k];
        end
      end
    end
  end

  assign done_o = s_v[NPAT] & s_eop[NPAT];
  assign vec_o  = s_vec[NPAT];

endmodule

// File: rtl/scan_dispatch.sv
module scan_dispatch #(
  parameter int NLANE = 4,
  parameter int LW    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_eop,
  output logic [NLANE-1:0] lane_v
);

  logic [LW-1:0] cur_q, cur_d;

  always_comb begin
    cur_d = cur_q;
    if (in_valid && in_eop)
      cur_d = (cur_q == LW'(NLANE - 1)) ? '0 : cur_q + 1'b1;
    lane_v = '0;
    lane_v[cur_q] = in_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_q <= '0;
    else        cur_q <= cur_d;
  end

  // R10: a packet stays on its lane until its last byte
  p_hold_lane_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_eop) |=> (cur_q == $past(cur_q)));

  // R10: a finished packet moves the pointer to another lane
  p_next_lane_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_eop && NLANE > 1) |=> (cur_q != $past(cur_q)));

endmodule

// File: rtl/scan_collect.sv
module scan_collect
  import scan_pkg::*;
#(
  parameter int NLANE = 4,
  parameter int LW    = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NLANE-1:0]           lane_done,
  input  logic [NLANE-1:0][NPAT-1:0] lane_vec,
  output logic                       out_valid,
  output logic [NPAT-1:0]            out_vec
);

  logic [LW-1:0]   rd_q, rd_d;
  logic            ov_q, ov_d;
  logic [NPAT-1:0] vec_q, vec_d;

  always_comb begin
    ov_d  = lane_done[rd_q];
    vec_d = ov_d ? lane_vec[rd_q] : vec_q;
    rd_d  = rd_q;
    if (ov_d) rd_d = (rd_q == LW'(NLANE - 1)) ? '0 : rd_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      ov_q  <= 1'b0;
      vec_q <= '0;
    end else begin
      rd_q  <= rd_d;
      ov_q  <= ov_d;
      vec_q <= vec_d;
    end
  end

  assign out_valid = ov_q;
  assign out_vec   = vec_q;

  // R2: lanes never finish two packets in the same cycle
  p_one_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lane_done));

  // R10: the lane that finishes is always the one next in arrival order
  p_in_order_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (|lane_done) |-> lane_done[rd_q]);

endmodule

// File: rtl/payload_scanner.sv
module payload_scanner
  import scan_pkg::*;
#(
  parameter int NLANE = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [7:0]      in_byte,
  input  logic            in_sop,
  input  logic            in_eop,
  output logic            out_valid,
  output logic [NPAT-1:0] out_vec
);

  localparam int LW = (NLANE > 1) ? $clog2(NLANE) : 1;

  logic [NLANE-1:0]           lane_v;
  logic [NLANE-1:0]           lane_done;
  logic [NLANE-1:0][NPAT-1:0] lane_vec;

  scan_dispatch #(.NLANE(NLANE), .LW(LW)) u_dispatch (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_eop   (in_eop),
    .lane_v   (lane_v)
  );

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    scan_lane u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .in_v    (lane_v[g]),
      .in_byte (in_byte),
      .in_sop  (in_sop),
      .in_eop  (in_eop),
      .done_o  (lane_done[g]),
      .vec_o   (lane_vec[g])
    );
  end

  scan_collect #(.NLANE(NLANE), .LW(LW)) u_collect (
    .clk       (clk),
    .rst_n     (rst_n),
    .lane_done (lane_done),
    .lane_vec  (lane_vec),
    .out_valid (out_valid),
    .out_vec   (out_vec)
  );

endmodule

// File: tb/test_payload_scanner.sv
module test_payload_scanner;
  import scan_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int WDOG       = 50000;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            in_valid, in_sop, in_eop;
  logic [7:0]      in_byte;
  logic            out_valid;
  logic [NPAT-1:0] out_vec;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  logic [NPAT-1:0] q_vec [$];
  int              q_cyc [$];
  string           q_tag [$];
  logic [NPAT-1:0] e_vec;
  int              e_cyc;
  string           e_tag;

  payload_scanner i_payload_scanner (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_byte   (in_byte),
    .in_sop    (in_sop),
    .in_eop    (in_eop),
    .out_valid (out_valid),
    .out_vec   (out_vec)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Each vector is compared at the cycle R2 predicts: NPAT+1 edges after eop.
  always @(negedge clk) begin
    if (rst_n === 1'b1 && out_valid === 1'b1) begin
      if (q_vec.size() == 0) begin
        check(1'b0, "R2", "unexpected out_valid, out_vec", int'(out_vec), 0);
      end else begin
        e_vec = q_vec.pop_front();
        e_cyc = q_cyc.pop_front();
        e_tag = q_tag.pop_front();
        check(out_vec === e_vec, e_tag, "out_vec", int'(out_vec), int'(e_vec));
        check(cyc == e_cyc, "R2", {"latency of ", e_tag}, cyc, e_cyc);
      end
    end
  end

  task automatic send(input string s, input int gap,
                      input logic [NPAT-1:0] exp, input string tag);
    for (int i = 0; i < s.len(); i++) begin
      if (i > 0) begin
        repeat (gap) begin
          @(negedge clk);
          in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
        end
      end
      @(negedge clk);
      in_valid = 1'b1;
      in_byte  = s[i];
      in_sop   = (i == 0);
      in_eop   = (i == s.len() - 1);
      if (in_eop) begin
        q_vec.push_back(exp);
        q_cyc.push_back(cyc + NPAT + 1);
        q_tag.push_back(tag);
      end
    end
  endtask

  task automatic idle_drain();
    @(negedge clk);
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
    while (q_vec.size() > 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_byte = '0;
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
    check(out_vec === '0, "R1", "out_vec in reset", int'(out_vec), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
    check(out_vec === '0, "R1", "out_vec after reset", int'(out_vec), 0);
  endtask

  task automatic t_case();
    send("call now!!", 0, 4'b0001, "R4/R3 lower case");
    idle_drain();
    send("CaLL nOw", 0, 4'b0001, "R4 mixed case");
    idle_drain();
  endtask

  task automatic t_any();
    send("winter", 0, 4'b0100, "R5 one byte");
    idle_drain();
    send("winer", 0, 4'b0000, "R5 zero bytes");
    idle_drain();
  endtask

  task automatic t_star();
    send("moneyfast", 0, 4'b1000, "R6 empty run");
    idle_drain();
    send("money is fast", 0, 4'b1000, "R6 long run");
    idle_drain();
    send("money fas", 0, 4'b0000, "R6 incomplete");
    idle_drain();
  endtask

  task automatic t_alt();
    send("0ffer", 0, 4'b0010, "R7 digit");
    idle_drain();
    send("an offer", 0, 4'b0010, "R7 letter");
    idle_drain();
    send("qffer", 0, 4'b0000, "R7 other");
    idle_drain();
  endtask

  task automatic t_overlap();
    send("calcall now", 0, 4'b0001, "R8 restart");
    idle_drain();
    send("wiwinner", 0, 4'b0100, "R8 overlap");
    idle_drain();
  endtask

  task automatic t_sticky();
    send("call now and more", 0, 4'b0001, "R9 sticky");
    send("hello", 0, 4'b0000, "R9 cleared");
    send("call ", 0, 4'b0000, "R9 split head");
    send("now", 0, 4'b0000, "R9 split tail");
    idle_drain();
  endtask

  task automatic t_order();
    send("winter", 0, 4'b0100, "R10 pkt0");
    send("x", 0, 4'b0000, "R10 pkt1");
    send("moneyfast", 0, 4'b1000, "R10 pkt2");
    send("0ffer", 0, 4'b0010, "R10 pkt3");
    send("call now", 0, 4'b0001, "R10 pkt4");
    send("a", 0, 4'b0000, "R10 pkt5");
    idle_drain();
  endtask

  task automatic t_gaps();
    send("CALL NOW WINNER MONEY FAST OFFER", 2, 4'b1111, "R11/R3 gaps");
    idle_drain();
  endtask

  initial begin
    t_reset();
    t_case();
    t_any();
    t_star();
    t_alt();
    t_overlap();
    t_sticky();
    t_order();
    t_gaps();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", WDOG);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule